// File: doc/BRIEF.md
# Multi-channel prescaled PWM generator

This block drives a bank of pulse-width modulated outputs that all share one period. A common prescaler divides the input clock into a local tick. A frame counter counts 256 ticks per frame, and every channel compares that count against its own 8-bit duty code. The frame length is fixed, so the only way to change the period is to change the prescaler, and any prescaler change affects every output at once.

Software configures the block through a plain one-cycle write strobe with a byte address and a 32-bit data word. It has no read path and no back-pressure: every strobe is taken in the cycle it is presented. Duty and prescaler writes go into staging registers. The running channels pick them up only at the next frame boundary, so a write never cuts a pulse short or stretches it.

A single enable bit gates the whole bank. While the enable bit is clear, every output stays low, the counters stay at zero, and staged values pass straight through to the active registers. Enabling the bank therefore always starts a clean frame with the values most recently written.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low and the bank is disabled.
- R2: A frame lasts 256 local ticks, and a local tick lasts (prescale + 1) input clocks. The period of every output is therefore 256 × (prescale + 1) clocks.
- R3: The 8-bit prescale value is written at byte address 0x40. Its low nibble comes from data bits [3:0] and its high nibble from data bits [14:11]. Data bits [8:4] have no effect on the prescale value.
- R4: With duty code D, an output is high for D + 1 ticks at the start of each frame and low for the other 255 − D ticks. A code of 0 gives a one-tick pulse.
- R5: A duty code of 255 keeps the output high for the whole frame, with no low interval.
- R6: Data bit 9 of the control word at byte address 0x40 enables all channels together. When it is cleared, all outputs go low within three clocks and stay low. When it is set again, the frame restarts from tick 0, so the first pulse begins two clocks after the write edge.
- R7: The duty code of channel c is written at byte address 4·c, using data bits [7:0].
- R8: While the bank is enabled, duty and prescale writes take effect only at the next frame boundary. The frame in progress finishes with its old values.
- R9: A write to an address that is not mapped, including an unaligned address, changes no setting.
- R10: Each channel's high time follows only its own duty code, while all channels share the same period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe; one write per cycle it is high |
| wr_addr | input | 7 | Byte address of the write |
| wr_data | input | 32 | Write data |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
Assertions check on every cycle the invariants that are local to one piece of logic. The prescale count never passes its limit, and the frame counter only moves on a tick and wraps to zero. Active duty and prescale values hold between frame boundaries, every output is low whenever the bank is not running, a code of 255 keeps its output high, and a code of 0 keeps its output low after tick 0. A write that decodes to no register leaves every staging value unchanged. Only the bench scenarios show the end-to-end timing: measured pulse widths and periods against the duty and prescale codes, the split prescale nibbles, the restart position after enable, and the way a write in mid-frame is deferred to the following frame.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  // Register map (byte addresses) and control-word field positions
  localparam int unsigned CTRL_OFFS = 32'h40;
  localparam int unsigned EN_POS    = 9;
  localparam int unsigned PSLO_POS  = 0;
  localparam int unsigned PSHI_POS  = 11;
  localparam int unsigned CH_STRIDE = 4;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8,
  parameter int PS_W   = 8,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  output logic                           en_o,
  output logic [PS_W-1:0]                ps_stage_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]   duty_stage_o
);
  localparam int HALF = PS_W / 2;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFFS);

  logic              ctrl_hit;
  logic [NUM_CH-1:0] duty_hit;
  logic              any_hit;

  assign ctrl_hit = wr_en && (wr_addr == CTRL_A);
  assign any_hit  = ctrl_hit || (|duty_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o       <= 1'b0;
      ps_stage_o <= '0;
    end else if (ctrl_hit) begin
      en_o       <= wr_data[EN_POS];
      ps_stage_o <= {wr_data[PSHI_POS +: HALF], wr_data[PSLO_POS +: HALF]};
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_duty
    localparam logic [ADDR_W-1:0] DUTY_A = ADDR_W'(CH_STRIDE * c);
    assign duty_hit[c] = wr_en && (wr_addr == DUTY_A);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           duty_stage_o[c] <= '0;
      else if (duty_hit[c]) duty_stage_o[c] <= wr_data[CNT_W-1:0];
    end
  end

  // R9: a write that decodes to nothing leaves all staged settings alone
  assert_ignore_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !any_hit) |=> ($stable(en_o) && $stable(ps_stage_o) && $stable(duty_stage_o)));
endmodule

// File: rtl/pwm_bank_timebase.sv
module pwm_bank_timebase #(
  parameter int CNT_W = 8,
  parameter int PS_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [PS_W-1:0]  ps_stage_i,
  output logic             run_o,
  output logic [CNT_W-1:0] frame_o,
  output logic             load_o
);
  localparam logic [CNT_W-1:0] FRAME_LAST = '1;

  logic [PS_W-1:0] ps_act;
  logic [PS_W-1:0] ps_cnt;
  logic            tick;
  logic            wrap;

  assign tick   = run_o && (ps_cnt == ps_act);
  assign wrap   = tick && (frame_o == FRAME_LAST);
  assign load_o = !run_o || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_o <= 1'b0;
    else        run_o <= en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ps_act <= '0;
    else if (load_o) ps_act <= ps_stage_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ps_cnt <= '0;
    else if (!run_o) ps_cnt <= '0;
    else if (tick)   ps_cnt <= '0;
    else             ps_cnt <= ps_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      frame_o <= '0;
    else if (!run_o) frame_o <= '0;
    else if (tick)   frame_o <= frame_o + 1'b1;
  end

  assert_ps_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> (ps_cnt <= ps_act));
  assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (frame_o == '0));
  assert_frame_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !tick) |=> ((frame_o == $past(frame_o)) || !run_o));
  assert_ps_shadow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !wrap) |=> $stable(ps_act));
endmodule

// File: rtl/pwm_bank_channel.sv
module pwm_bank_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] frame_i,
  input  logic [CNT_W-1:0] duty_stage_i,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] DUTY_FULL = '1;

  logic [CNT_W-1:0] duty_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      duty_act <= '0;
    else if (load_i) duty_act <= duty_stage_i;
  end

  // Output is registered so a compare settling mid-cycle never reaches the pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_o <= 1'b0;
    else        pwm_o <= run_i && (frame_i <= duty_act);
  end

  assert_full_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && duty_act == DUTY_FULL) |=> pwm_o);
  assert_zero_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && duty_act == '0 && frame_i != '0) |=> !pwm_o);
  assert_duty_shadow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(duty_act));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8,
  parameter int PS_W   = 8,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_CH-1:0] pwm_out
);
  logic                         en;
  logic [PS_W-1:0]              ps_stage;
  logic [NUM_CH-1:0][CNT_W-1:0] duty_stage;
  logic                         run;
  logic [CNT_W-1:0]             frame;
  logic                         load;

  pwm_bank_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PS_W(PS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_o(en), .ps_stage_o(ps_stage), .duty_stage_o(duty_stage)
  );

  pwm_bank_timebase #(.CNT_W(CNT_W), .PS_W(PS_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .en_i(en), .ps_stage_i(ps_stage),
    .run_o(run), .frame_o(frame), .load_o(load)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_bank_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .run_i(run), .load_i(load), .frame_i(frame),
      .duty_stage_i(duty_stage[c]), .pwm_o(pwm_out[c])
    );
  end

  assert_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pwm_out == '0));
  assert_reset_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !run) |=> !run);
endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [6:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0] pwm_out;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_bank u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                  .wr_data(wr_data), .pwm_out(pwm_out));

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] ctrl(input logic [7:0] ps, input bit en);
    return (32'(ps[7:4]) << 11) | 32'(ps[3:0]) | (32'(en) << 9);
  endfunction

  // Waits for a rising edge on channel ch, then counts high and low samples
  task automatic meas(input int ch, output int hi, output int lo);
    bit prev = pwm_out[ch];
    bit found = 1'b0;
    hi = -1; lo = -1;
    for (int n = 0; n < 12000; n++) begin
      @(negedge clk);
      if (!prev && pwm_out[ch]) begin found = 1'b1; break; end
      prev = pwm_out[ch];
    end
    if (found) begin
      hi = 1;
      for (int n = 0; n < 12000; n++) begin
        @(negedge clk);
        if (pwm_out[ch]) hi++; else break;
      end
      lo = 1;
      for (int n = 0; n < 12000; n++) begin
        @(negedge clk);
        if (!pwm_out[ch]) lo++; else break;
      end
    end
  endtask

  task automatic t_reset;
    int bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_out != 4'b0) bad++;
    end
    check("R1 outputs low after reset", bad, 0);
  endtask

  task automatic t_multi;
    int hi, lo, bad;
    wr(7'h00, 32'h00);
    wr(7'h04, 32'h7F);
    wr(7'h08, 32'hFF);
    wr(7'h0C, 32'h20);
    wr(7'h40, ctrl(8'h00, 1'b1));
    meas(0, hi, lo);
    check("R4 duty 0 high ticks", hi, 1);
    check("R2 period ps=0 ch0", hi + lo, 256);
    meas(1, hi, lo);
    check("R10 ch1 duty 0x7F high", hi, 128);
    check("R7 ch1 period", hi + lo, 256);
    meas(3, hi, lo);
    check("R10 ch3 duty 0x20 high", hi, 33);
    bad = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!pwm_out[2]) bad++;
    end
    check("R5 duty 255 never low", bad, 0);
  endtask

  task automatic t_split;
    int hi, lo;
    // prescale 0x12 plus a stray bit 5 that must be ignored
    wr(7'h40, ctrl(8'h12, 1'b1) | 32'h20);
    meas(1, hi, lo);
    check("R3 split prescale high time", hi, 128 * 19);
    check("R3 split prescale period", hi + lo, 256 * 19);
  endtask

  task automatic t_duty_shadow;
    int hi, lo, cnt;
    wr(7'h40, ctrl(8'h00, 1'b1));
    wr(7'h00, 32'd50);
    meas(0, hi, lo);
    check("R4 duty 50 high", hi, 51);
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      if (!pwm_out[0]) break;
    end
    wr_en = 1'b1; wr_addr = 7'h00; wr_data = 32'd200;
    cnt = 1;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (!pwm_out[0]) cnt++; else break;
    end
    check("R8 duty write deferred, low unchanged", cnt, 205);
    hi = 1;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if (pwm_out[0]) hi++; else break;
    end
    check("R8 new duty after boundary", hi, 201);
  endtask

  task automatic t_ps_shadow;
    int hi, lo, cnt;
    wr(7'h00, 32'd50);
    meas(0, hi, lo);
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      if (!pwm_out[0]) break;
    end
    wr_en = 1'b1; wr_addr = 7'h40; wr_data = ctrl(8'h01, 1'b1);
    cnt = 1;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (!pwm_out[0]) cnt++; else break;
    end
    check("R8 prescale write deferred", cnt, 205);
    hi = 1;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if (pwm_out[0]) hi++; else break;
    end
    check("R2 high time at prescale 1", hi, 102);
  endtask

  task automatic t_disable;
    int bad = 0, wait_n = 0, hi;
    wr(7'h40, ctrl(8'h00, 1'b0));
    repeat (3) @(negedge clk);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (pwm_out != 4'b0) bad++;
    end
    check("R6 disabled outputs low", bad, 0);
    wr(7'h00, 32'd9);
    wr(7'h40, ctrl(8'h00, 1'b1));
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      wait_n++;
      if (pwm_out[0]) break;
    end
    check("R6 restart at tick 0", wait_n, 2);
    hi = 1;
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      if (pwm_out[0]) hi++; else break;
    end
    check("R6 first pulse after enable", hi, 10);
  endtask

  task automatic t_unmapped;
    int hi, lo;
    wr(7'h44, 32'h0);
    wr(7'h42, 32'h0);
    wr(7'h01, 32'hFF);
    meas(0, hi, lo);
    check("R9 unmapped write ignored high", hi, 10);
    check("R9 unmapped write ignored period", hi + lo, 256);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_multi();
    t_split();
    t_duty_shadow();
    t_ps_shadow();
    t_disable();
    t_unmapped();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule